// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Port

This block is an eight-bit, three-wire synchronous serial port built around one shift register. A transfer moves the register's contents out on the serial-out line, most significant bit first, while the bits arriving on the serial-in line are shifted into it. In master mode the port generates the serial clock itself by dividing the system clock by a fixed factor. In slave mode it follows an external serial clock. That external clock is passed through a two-flop synchronizer and an edge detector before it is used.

Two enables set the direction of the port. Transmit-enable alone gives transmit-only operation, receive-enable alone gives receive-only operation, and both together give full duplex. How a transfer starts depends on this setting: a write to the register, a read of it, or a rising receive-enable. A one-cycle completion pulse marks a finished transfer. If an enable is dropped during a transfer, the transfer is abandoned and no completion pulse is raised.

Top module: `sync_serial_port`

## Requirements
- R1: While reset is held, `sck_o` is high, `so_oe_o` is low, `done_o` is low and `rdata_o` is 0x00.
- R2: `so_oe_o` is high exactly when `tx_en_i` is high; otherwise the serial-out line is released to high impedance.
- R3: With only `tx_en_i` set, a `wr_i` pulse loads `wdata_i` and starts a transfer. A write while both enables are clear only loads the register: no serial clock is generated and no completion is signalled.
- R4: With only `rx_en_i` set, a transfer starts on the 0 to 1 change of `rx_en_i` or on an `rd_i` pulse.
- R5: With both enables set, a transfer starts on the 0 to 1 change of `rx_en_i` or on a `wr_i` pulse. A byte preloaded while both enables were clear is the first byte sent.
- R6: A transfer is 8 bits, MSB first. `so_o` changes on falling serial-clock edges, `si_i` is sampled on rising edges, and after completion `rdata_o` holds the 8 bits received, the first one received in bit 7.
- R7: After the eighth rising edge, `done_o` is high for exactly one system-clock cycle. In master mode `sck_o` then stays high.
- R8: In master mode the serial-clock period is `CLK_DIV` system clocks. The first falling edge comes no later than `CLK_DIV` clocks after the start is accepted.
- R9: In master mode, clearing the active enable during a transfer stops the serial clock. `sck_o` returns high by the next rising edge and stays there, and no `done_o` pulse follows.
- R10: In slave mode, serial-clock edges that arrive before a transfer is started do not change the register or `so_o`.
- R11: In slave mode, clearing the active enable during a transfer halts it at once. Later serial-clock edges change nothing, no `done_o` pulse is raised, and a later transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate the serial clock; 0: follow `sck_i` |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable; its rising edge can start a transfer |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rd_i | input | 1 | Register read strobe |
| rdata_o | output | 8 | Shift register contents |
| sck_i | input | 1 | External serial clock (slave mode) |
| sck_o | output | 1 | Generated serial clock, idles high |
| sck_oe_o | output | 1 | Drive enable for `sck_o` (master mode) |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for serial-out |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest states to reach are the two aborts, because the enable must fall while a transfer is partly done. In master mode the stimulus counts the port's own `sck_o` rising edges and drops transmit-enable after the third. It then watches over several periods that no further falling edge and no completion pulse appears. In slave mode the bench supplies three external clock cycles, clears the enable, and then keeps clocking. It checks that the register no longer moves and that a fresh transfer afterwards completes correctly.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic tx;
    logic rx;
  } ssp_dir_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PW   = $clog2(DIV);

  logic [PW-1:0] ph_q;
  logic          sck_q;
  logic          active;

  // a low phase in progress always completes, so the line parks high
  assign active = run_i | ~sck_q;
  assign fall_o = run_i & sck_q & (ph_q == PW'(HALF - 1));
  assign rise_o = ~sck_q & (ph_q == PW'(DIV - 1));
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      sck_q <= 1'b1;
    end else begin
      if (!active)                    ph_q <= '0;
      else if (ph_q == PW'(DIV - 1))  ph_q <= '0;
      else                            ph_q <= ph_q + 1'b1;
      if (fall_o)      sck_q <= 1'b0;
      else if (rise_o) sck_q <= 1'b1;
    end
  end

  assert_clock_parks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && sck_q) |=> sck_q);
  assert_low_phase_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_q) |-> ph_q == PW'(HALF));
endmodule

// File: rtl/ssp_edge.sv
module ssp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= sck_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
  import ssp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_en_i,
  input  logic         rx_en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  input  logic         sck_idle_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         si_i,
  output logic         busy_o,
  output logic [W-1:0] data_o,
  output logic         so_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sreg_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, so_q, rx_en_q;
  ssp_dir_t      dir_q;
  logic          start, abort;

  assign start = ~busy_q & sck_idle_i &
                 ((tx_en_i & wr_i) | (rx_en_i & ~tx_en_i & rd_i) | (rx_en_i & ~rx_en_q));
  assign abort = busy_q & ((dir_q.tx & ~tx_en_i) | (dir_q.rx & ~rx_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      so_q    <= 1'b0;
      rx_en_q <= 1'b0;
      dir_q   <= '0;
    end else begin
      rx_en_q <= rx_en_i;
      done_q  <= 1'b0;
      if (!busy_q) begin
        if (wr_i) sreg_q <= wdata_i;
        if (start) begin
          busy_q   <= 1'b1;
          cnt_q    <= '0;
          dir_q.tx <= tx_en_i;
          dir_q.rx <= rx_en_i;
        end
      end else if (abort) begin
        busy_q <= 1'b0;
      end else begin
        if (fall_i) so_q <= sreg_q[W-1];
        if (rise_i) begin
          sreg_q <= {sreg_q[W-2:0], si_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CW'(W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign data_o = sreg_q;
  assign so_o   = so_q;
  assign done_o = done_q;

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_last_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(cnt_q) == CW'(W - 1) && $past(busy_q));
  assert_abort_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !busy_q && !done_q);
  assert_idle_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !wr_i) |=> $stable(sreg_q) && $stable(so_q));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              done_o
);
  logic busy, m_sck, m_rise, m_fall, s_rise, s_fall;
  logic rise, fall, sck_idle;

  ssp_clkgen #(.DIV(CLK_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (master_i & busy),
    .sck_o  (m_sck),
    .fall_o (m_fall),
    .rise_o (m_rise)
  );

  ssp_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign rise     = master_i ? m_rise : s_rise;
  assign fall     = master_i ? m_fall : s_fall;
  assign sck_idle = ~master_i | m_sck;

  ssp_shift #(.W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .rx_en_i    (rx_en_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rd_i       (rd_i),
    .sck_idle_i (sck_idle),
    .rise_i     (rise),
    .fall_i     (fall),
    .si_i       (si_i),
    .busy_o     (busy),
    .data_o     (rdata_o),
    .so_o       (so_o),
    .done_o     (done_o)
  );

  assign sck_o    = master_i ? m_sck : 1'b1;
  assign sck_oe_o = master_i;
  assign so_oe_o  = tx_en_i;

  assert_done_idles_clock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && master_i) |-> m_sck);
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  // {master, tx_en, rx_en, pad, tx byte, rx byte}
  localparam logic [19:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hC3},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 8'h7E},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h96},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h80}
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       master = 1'b1, tx_en = 1'b0, rx_en = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic       sck_in = 1'b1, si_m = 1'b0, si_s = 1'b0;
  logic [7:0] rdata;
  logic       sck_o, sck_oe, so_o, so_oe, done_o, si;

  int tests = 0, fails = 0, cyc = 0, done_cnt = 0;
  int fall_total = 0, rise_total = 0, fall_base = 0, mon_idx;
  int first_fall_cyc = 0, second_fall_cyc = 0;
  logic       sck_d = 1'b1;
  logic [7:0] m_rx = '0, m_so = '0;
  bit finished = 0;

  assign si = master ? si_m : si_s;

  sync_serial_port #(.DATA_W(8), .CLK_DIV(DIV)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .sck_i(sck_in), .sck_o(sck_o),
    .sck_oe_o(sck_oe), .si_i(si), .so_o(so_o), .so_oe_o(so_oe), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && done_o) done_cnt <= done_cnt + 1;
  end

  // bench-side slave for master mode: drive si after each fall, capture so at each rise
  always @(negedge clk_i) begin
    sck_d <= sck_o;
    if (sck_d && !sck_o) begin
      mon_idx = fall_total - fall_base;
      if (mon_idx == 0) first_fall_cyc <= cyc;
      if (mon_idx == 1) second_fall_cyc <= cyc;
      if (mon_idx < 8) si_m <= m_rx[7 - mon_idx];
      fall_total <= fall_total + 1;
    end
    if (!sck_d && sck_o) begin
      rise_total <= rise_total + 1;
      m_so <= {m_so[6:0], so_o};
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_wr(logic [7:0] b);
    wdata = b; wr = 1'b1; tick(1); wr = 1'b0;
  endtask

  task automatic pulse_rd();
    rd = 1'b1; tick(1); rd = 1'b0;
  endtask

  task automatic wait_done(int base);
    for (int g = 0; g < 4000 && done_cnt == base; g++) tick(1);
  endtask

  task automatic slave_bits(int n, logic [7:0] rxb, output logic [7:0] sob);
    sob = '0;
    for (int i = 0; i < n; i++) begin
      sck_in = 1'b0; tick(4);
      sob[7-i] = so_o;
      si_s = rxb[7-i];
      tick(1);
      sck_in = 1'b1; tick(4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] sob, tmp, r0;
    logic vm, vt, vr, pad;
    logic [7:0] txb, rxb;
    int db, fb, c0, rb;
    logic so0;

    tick(3);
    check(sck_o == 1'b1, "R1 sck_o in reset", sck_o, 1);
    check(so_oe == 1'b0, "R1 so_oe_o in reset", so_oe, 0);
    check(done_o == 1'b0, "R1 done_o in reset", done_o, 0);
    check(rdata == 8'h00, "R1 rdata_o in reset", rdata, 0);
    rst_ni = 1'b1;
    tick(2);

    tx_en = 1'b1; tick(1);
    check(so_oe == 1'b1, "R2 so_oe_o with tx_en", so_oe, 1);
    tx_en = 1'b0; tick(1);
    check(so_oe == 1'b0, "R2 so_oe_o released", so_oe, 0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      {vm, vt, vr, pad, txb, rxb} = VEC[v];
      master = vm; tx_en = 1'b0; rx_en = 1'b0; tick(2);
      fall_base = fall_total; m_rx = rxb; db = done_cnt;
      if (vr) begin
        pulse_wr(txb);            // preload, both enables clear
        tx_en = vt; rx_en = 1'b1; tick(1);
      end else begin
        tx_en = 1'b1; tick(1);
        pulse_wr(txb);
      end
      if (vm) wait_done(db); else slave_bits(8, rxb, sob);
      tick(4);
      check(done_cnt == db + 1, vr ? (vt ? "R5 R7 done after rx_en rise" : "R4 R7 done after rx_en rise")
                                   : "R3 R7 done after write", done_cnt - db, 1);
      check(rdata == rxb, "R6 received byte", rdata, rxb);
      if (vt) check((vm ? m_so : sob) == txb, vr ? "R5 R6 sent preloaded byte" : "R6 sent byte",
                    vm ? m_so : sob, txb);
      if (vm) check(sck_o == 1'b1, "R7 sck_o idles high", sck_o, 1);
    end

    // R3: write with both enables clear only loads
    master = 1'b1; tx_en = 1'b0; rx_en = 1'b0; tick(2);
    fb = fall_total; db = done_cnt;
    pulse_wr(8'h3C); tick(5 * DIV);
    check(fall_total == fb, "R3 no clock on preload", fall_total - fb, 0);
    check(done_cnt == db, "R3 no done on preload", done_cnt - db, 0);
    check(rdata == 8'h3C, "R3 preload stored", rdata, 8'h3C);

    // R4: rx-only, rise start then read start
    fall_base = fall_total; m_rx = 8'h11; db = done_cnt;
    rx_en = 1'b1; tick(1);
    wait_done(db); tick(4);
    fall_base = fall_total; m_rx = 8'h69; db = done_cnt;
    pulse_rd();
    wait_done(db); tick(4);
    check(done_cnt == db + 1, "R4 read starts transfer", done_cnt - db, 1);
    check(rdata == 8'h69, "R4 read-started data", rdata, 8'h69);

    // R5 + R8: write start in full duplex, clock timing
    tx_en = 1'b1; tick(1);
    fall_base = fall_total; m_rx = 8'hD2; db = done_cnt;
    c0 = cyc;
    pulse_wr(8'h4B);
    wait_done(db); tick(4);
    check(m_so == 8'h4B, "R5 write-start sent byte", m_so, 8'h4B);
    check(rdata == 8'hD2, "R5 write-start received", rdata, 8'hD2);
    check(first_fall_cyc - c0 >= 1 && first_fall_cyc - c0 <= DIV + 1, "R8 first fall latency",
          first_fall_cyc - c0, DIV / 2 + 1);
    check(second_fall_cyc - first_fall_cyc == DIV, "R8 clock period",
          second_fall_cyc - first_fall_cyc, DIV);

    // R9: master abort
    tx_en = 1'b0; rx_en = 1'b0; tick(2);
    tx_en = 1'b1; tick(1);
    fall_base = fall_total; m_rx = 8'h00; db = done_cnt; rb = rise_total;
    pulse_wr(8'hF0);
    for (int g = 0; g < 2000 && rise_total - rb < 3; g++) tick(1);
    tx_en = 1'b0;
    tick(3 * DIV);
    fb = fall_total;
    tick(3 * DIV);
    check(fall_total == fb, "R9 clock stopped", fall_total - fb, 0);
    check(sck_o == 1'b1, "R9 sck_o parked high", sck_o, 1);
    check(done_cnt == db, "R9 no done on abort", done_cnt - db, 0);
    check(so_oe == 1'b0, "R9 so released", so_oe, 0);

    // R10: slave edges before start
    master = 1'b0; tick(2);
    pulse_wr(8'hA7);
    tx_en = 1'b1; tick(2);
    so0 = so_o; db = done_cnt;
    slave_bits(8, 8'h00, tmp);
    tick(4);
    check(rdata == 8'hA7, "R10 register untouched", rdata, 8'hA7);
    check(so_o == so0, "R10 so_o unchanged", so_o, so0);
    check(done_cnt == db, "R10 no done", done_cnt - db, 0);

    // R11: slave abort, then recovery
    db = done_cnt;
    pulse_wr(8'hC6);
    slave_bits(3, 8'hFF, tmp);
    tx_en = 1'b0; tick(2);
    r0 = rdata;
    slave_bits(8, 8'h55, tmp);
    tick(4);
    check(rdata == r0, "R11 later edges ignored", rdata, r0);
    check(done_cnt == db, "R11 no done on abort", done_cnt - db, 0);
    tx_en = 1'b1; tick(2);
    pulse_wr(8'h3A);
    slave_bits(8, 8'h5C, sob);
    tick(4);
    check(sob == 8'h3A, "R11 recovery sent", sob, 8'h3A);
    check(rdata == 8'h5C, "R11 recovery received", rdata, 8'h5C);
    check(done_cnt == db + 1, "R11 recovery done", done_cnt - db, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule